// File: doc/BRIEF.md
# Oversampled serial receiver with flag-tagged receive queue

This block turns an asynchronous serial line into characters. A 16x sampling enable comes from outside, so the block contains no divisor logic. After a falling edge on the line, the block confirms the start bit at its middle. It then takes one sample at the centre of each data, parity and stop bit. The character length (5 to 8 bits) and the parity mode (none, even or odd) are set by static configuration inputs, which change only between characters.

Each completed character goes into a 16-entry queue. The data byte is stored in the same entry as three error tags: parity, framing and break. The consumer reads the entry at the head of the queue and removes it with a one-cycle pop strobe. The block also reports a data-ready level and the number of stored entries. If a character finishes while the queue is full, the character is lost and a sticky overrun flag is set. A status-read strobe clears that flag.

Top module: `uart_rx_efifo`

## Requirements
- R1: After reset, `fill` is 0, `data_ready` is 0 and `overrun` is 0.
- R2: `cfg_len` selects the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first and are placed in `rd_data` from bit 0 upward. Data bits above the character length read as 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. `cfg_par_odd`=0 expects an even number of ones across data and parity. `cfg_par_odd`=1 expects an odd number. A mismatch sets `rd_perr` for that entry. When `cfg_par_en` is 0, no parity bit is taken and `rd_perr` is 0.
- R4: A start is confirmed only if the line is still low 8 sampling ticks after the tick that first saw it low. If the line is high at that point, the receiver returns to idle and stores nothing.
- R5: If the sample taken at the middle of the first stop bit is low, `rd_ferr` is set for that entry. The received data is kept.
- R6: If every sample of a frame is low, from the start bit through the stop bit, one entry is stored with data 0, `rd_brk`=1, `rd_ferr`=1 and `rd_perr`=0. No further character is assembled until the line has returned high.
- R7: The queue holds 16 entries and returns them in arrival order. `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` show the oldest entry. `fill` counts the stored entries and never exceeds 16. `data_ready` is 1 exactly when `fill` is nonzero. A `pop` removes the oldest entry.
- R8: A `pop` while the queue is empty has no effect on `fill` or on later data.
- R9: A character that completes while 16 entries are stored is discarded and sets `overrun`. `overrun` stays set until a `stat_rd` pulse. If a new overrun occurs in the same cycle as `stat_rd`, `overrun` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Character length code (5 plus value) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Head entry data |
| rd_perr | output | 1 | Head entry parity error |
| rd_ferr | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_ready | output | 1 | Queue not empty |
| fill | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Two conditions are hard to reach from the ports. The first is a character completing against a full queue. The second is a break that must produce exactly one entry however long the line stays low. The bench sends seventeen back-to-back short frames without popping, then checks `overrun` before and after a status read, and then drains the queue. It also holds the line low for about three frame times. A rejected start is produced with a low pulse 6 ticks long, which lasts past detection but ends before the 8-tick confirmation point.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_HOLD
  } rx_state_e;

  typedef struct packed {
    logic              brk;
    logic              ferr;
    logic              perr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  // length code 0..3 maps to 5..8 data bits
  function automatic logic [3:0] char_bits(input logic [1:0] len);
    return 4'd5 + {2'b00, len};
  endfunction

  // even: total ones over data and parity bit must be even; odd: must be odd
  function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                      input logic pbit,
                                      input logic odd);
    return (^{d, pbit}) != odd;
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b1;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= 1'b1;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd_s,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  output logic       done,
  output rx_entry_t  entry,
  output logic       start_rej
);

  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;

  rx_state_e         state_q;
  logic [CW-1:0]     tcnt_q;
  logic [2:0]        bidx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              pbit_q;
  logic              all_low_q;

  logic mid_start;
  logic bit_end;
  logic last_bit;
  logic brk_now;

  assign mid_start = (tcnt_q == CW'(HALF - 1));
  assign bit_end   = (tcnt_q == CW'(OSR - 1));
  assign last_bit  = ({1'b0, bidx_q} == (char_bits(cfg_len) - 4'd1));
  assign brk_now   = all_low_q & ~rxd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= RX_IDLE;
      tcnt_q    <= '0;
      bidx_q    <= '0;
      shreg_q   <= '0;
      pbit_q    <= 1'b0;
      all_low_q <= 1'b0;
      done      <= 1'b0;
      start_rej <= 1'b0;
      entry     <= '0;
    end else begin
      done      <= 1'b0;
      start_rej <= 1'b0;
      if (tick) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rxd_s) begin
              state_q <= RX_START;
              tcnt_q  <= '0;
            end
          end
          RX_START: begin
            if (mid_start) begin
              if (rxd_s) begin
                state_q   <= RX_IDLE;
                start_rej <= 1'b1;
              end else begin
                state_q   <= RX_DATA;
                tcnt_q    <= '0;
                bidx_q    <= '0;
                shreg_q   <= '0;
                all_low_q <= 1'b1;
              end
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (bit_end) begin
              tcnt_q          <= '0;
              shreg_q[bidx_q] <= rxd_s;
              all_low_q       <= all_low_q & ~rxd_s;
              if (last_bit) state_q <= cfg_par_en ? RX_PAR : RX_STOP;
              else          bidx_q  <= bidx_q + 1'b1;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (bit_end) begin
              tcnt_q    <= '0;
              pbit_q    <= rxd_s;
              all_low_q <= all_low_q & ~rxd_s;
              state_q   <= RX_STOP;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (bit_end) begin
              tcnt_q     <= '0;
              done       <= 1'b1;
              entry.brk  <= brk_now;
              entry.ferr <= ~rxd_s;
              entry.perr <= cfg_par_en & ~brk_now &
                            parity_bad(shreg_q, pbit_q, cfg_par_odd);
              entry.data <= brk_now ? '0 : shreg_q;
              state_q    <= brk_now ? RX_HOLD : RX_IDLE;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
          RX_HOLD: begin
            if (rxd_s) state_q <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int FW   = AW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [FW-1:0] fill,
  output logic         full,
  output logic         empty
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [FW-1:0] wptr_q;
  logic [FW-1:0] rptr_q;
  logic          do_wr;
  logic          do_rd;

  assign fill  = wptr_q - rptr_q;
  assign full  = (fill == FW'(DEPTH));
  assign empty = (fill == '0);
  assign do_wr = push & ~full;
  assign do_rd = pop & ~empty;
  assign dout  = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_wr) mem_q[wptr_q[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_wr) wptr_q <= wptr_q + 1'b1;
      if (do_rd) rptr_q <= rptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/uart_rx_efifo.sv
module uart_rx_efifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  localparam int FW         = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rxd,
  input  logic [1:0]    cfg_len,
  input  logic          cfg_par_en,
  input  logic          cfg_par_odd,
  input  logic          pop,
  input  logic          stat_rd,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          data_ready,
  output logic [FW-1:0] fill,
  output logic          overrun
);

  logic      rxd_s;
  logic      ev_done;
  logic      ev_rej;
  logic      ev_drop;
  rx_entry_t ev_entry;
  rx_entry_t head;
  logic      q_full;
  logic      q_empty;
  logic      ovr_q;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rxd_s)
  );

  rx_frame #(.OSR(OSR)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick16),
    .rxd_s      (rxd_s),
    .cfg_len    (cfg_len),
    .cfg_par_en (cfg_par_en),
    .cfg_par_odd(cfg_par_odd),
    .done       (ev_done),
    .entry      (ev_entry),
    .start_rej  (ev_rej)
  );

  rx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .push (ev_done),
    .din  (ev_entry),
    .pop  (pop),
    .dout (head),
    .fill (fill),
    .full (q_full),
    .empty(q_empty)
  );

  assign ev_drop = ev_done & q_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ev_drop) ovr_q <= 1'b1;
    else if (stat_rd) ovr_q <= 1'b0;
  end

  assign overrun    = ovr_q;
  assign data_ready = ~q_empty;
  assign rd_data    = head.data;
  assign rd_perr    = head.perr;
  assign rd_ferr    = head.ferr;
  assign rd_brk     = head.brk;

endmodule

// File: rtl/uart_rx_efifo_chk.sv
module uart_rx_efifo_chk #(
  parameter int DEPTH = 16,
  localparam int FW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          ent_brk,
  input logic          ent_ferr,
  input logic          ent_perr,
  input logic [7:0]    ent_data,
  input logic          pop,
  input logic          stat_rd,
  input logic [FW-1:0] fill,
  input logic          overrun
);

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));

  p_push_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fill < FW'(DEPTH) && !pop) |=> fill == $past(fill) + FW'(1));

  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fill != '0 && !done) |=> fill == $past(fill) - FW'(1));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && fill == '0 && !done) |=> fill == '0);

  p_brk_tags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ent_brk) |-> (ent_ferr && !ent_perr && ent_data == 8'h00));

  p_drop_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fill == FW'(DEPTH)) |=> overrun);

  p_full_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fill == FW'(DEPTH) && !pop) |=> fill == FW'(DEPTH));

  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun);

  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && stat_rd && !(done && fill == FW'(DEPTH))) |=> !overrun);

endmodule

bind uart_rx_efifo uart_rx_efifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .done    (ev_done),
  .ent_brk (ev_entry.brk),
  .ent_ferr(ev_entry.ferr),
  .ent_perr(ev_entry.perr),
  .ent_data(ev_entry.data),
  .pop     (pop),
  .stat_rd (stat_rd),
  .fill    (fill),
  .overrun (overrun)
);

// File: tb/tb_uart_rx_efifo.sv
module tb_uart_rx_efifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       pop = 1'b0;
  logic       stat_rd = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, data_ready, overrun;
  logic [4:0] fill;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] tdiv = 2'd0;
  logic [10:0] exp_q[$];
  logic exp_ovr = 1'b0;
  bit finished = 0;

  uart_rx_efifo dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .pop(pop), .stat_rd(stat_rd), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .data_ready(data_ready),
    .fill(fill), .overrun(overrun)
  );

  always #10 clk = ~clk;

  // one sampling tick every 4 clocks
  always @(posedge clk) begin
    tdiv   <= tdiv + 2'd1;
    tick16 <= (tdiv == 2'd3);
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick16) @(posedge clk);
    end
  endtask

  task automatic drive(input logic v, input int n);
    @(negedge clk);
    rxd = v;
    wait_ticks(n);
  endtask

  function automatic logic ones_odd(input logic [7:0] d);
    int c = 0;
    for (int i = 0; i < 8; i++) if (d[i]) c++;
    return (c % 2) == 1;
  endfunction

  // send one frame and record what the receiver should store
  task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                            input logic pen, input logic odd,
                            input logic flip, input logic stopv);
    int nb = 5 + len;
    logic [7:0] dm = d & 8'((1 << nb) - 1);
    logic pb = (ones_odd(dm) ^ odd) ^ flip;
    logic [10:0] e;
    @(negedge clk);
    cfg_len = len; cfg_par_en = pen; cfg_par_odd = odd;
    wait_ticks(1);
    drive(1'b0, 16);
    for (int i = 0; i < nb; i++) drive(dm[i], 16);
    if (pen) drive(pb, 16);
    drive(stopv, 16);
    drive(1'b1, 3);
    if (dm == 8'h00 && (!pen || !pb) && !stopv) e = {3'b110, 8'h00};
    else e = {1'b0, !stopv, pen & flip, dm};
    if (exp_q.size() < 16) exp_q.push_back(e);
    else exp_ovr = 1'b1;
  endtask

  task automatic pop_check(input string req);
    logic [10:0] e = exp_q.pop_front();
    @(negedge clk);
    check({req, " data"}, rd_data, e[7:0]);
    check({req, " perr"}, rd_perr, e[8]);
    check({req, " ferr"}, rd_ferr, e[9]);
    check({req, " brk"},  rd_brk,  e[10]);
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic status_check(input string req);
    @(negedge clk);
    check({req, " fill"}, fill, exp_q.size());
    check({req, " data_ready"}, data_ready, exp_q.size() != 0);
    check({req, " overrun"}, overrun, exp_ovr);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    status_check("R1 reset");

    // R2: every length, upper bits must read zero
    for (int l = 0; l < 4; l++) begin
      send_frame(8'hA5, 2'(l), 1'b0, 1'b0, 1'b0, 1'b1);
      send_frame(8'h5A, 2'(l), 1'b0, 1'b0, 1'b0, 1'b1);
    end
    status_check("R2 lengths");
    while (exp_q.size() != 0) pop_check("R2 length");

    // R3: even and odd, good and bad parity
    send_frame(8'h37, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1);
    send_frame(8'h37, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    send_frame(8'h0B, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1);
    send_frame(8'h0B, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1);
    while (exp_q.size() != 0) pop_check("R3 parity");

    // R4: short low pulse rejected at the confirmation tick
    wait_ticks(1);
    drive(1'b0, 6);
    drive(1'b1, 24);
    status_check("R4 false start");

    // R5: framing error keeps data
    send_frame(8'h3C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    drive(1'b1, 20);
    status_check("R5 framing");
    pop_check("R5 framing");

    // R6: long break gives one entry only
    cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    wait_ticks(1);
    drive(1'b0, 16 * 33);
    drive(1'b1, 20);
    exp_q.push_back({3'b110, 8'h00});
    status_check("R6 break");
    pop_check("R6 break");
    send_frame(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    pop_check("R6 after break");

    // R8: pop on empty queue
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
    status_check("R8 empty pop");
    send_frame(8'h4E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    status_check("R8 after pop");
    pop_check("R8 after pop");

    // R9: seventeen frames without draining
    for (int i = 0; i < 17; i++)
      send_frame(8'(i + 1), 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    status_check("R9 overrun set");
    wait_ticks(4);
    status_check("R9 overrun sticky");
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    exp_ovr = 1'b0;
    status_check("R9 overrun cleared");
    while (exp_q.size() != 0) pop_check("R7 order");
    status_check("R7 drained");

    // R2 R3 R5 R7: random frames
    for (int i = 0; i < 40; i++) begin
      logic [1:0] l = 2'($urandom_range(0, 3));
      logic pe = 1'($urandom_range(0, 1));
      logic po = 1'($urandom_range(0, 1));
      logic fl = pe && ($urandom_range(0, 4) == 0);
      logic sv = ($urandom_range(0, 9) != 0);
      send_frame(8'($urandom), l, pe, po, fl, sv);
      if (!sv) drive(1'b1, 20);
      if ($urandom_range(0, 2) == 0 || exp_q.size() > 4) begin
        status_check("R7 random status");
        while (exp_q.size() != 0) pop_check("R7 random");
      end
    end
    while (exp_q.size() != 0) pop_check("R7 random tail");
    status_check("R7 final");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule